// File: doc/BRIEF.md
# ATA Data-Strobe Cycle Timer

This block times the read/write strobe of one parallel ATA data cycle, for either programmed-I/O or multiword-DMA transfers. It holds a small bank of byte-wide timing registers on a simple register bus. The bank has a PIO timing byte, a multiword-DMA timing byte shared by both drives, one ultra-DMA timing byte per drive and a clock-mode byte. A requester raises a cycle request and gives a transfer type and a target drive (0 or 1). The block then takes the active and recovery counts from the matching timing byte. It asserts the strobe for the active phase and keeps it deasserted for the recovery phase, and it then reports completion with a one-clock pulse.

Counts are in timing units, and one unit is two periods of the block clock, which runs from the reference clock. The clock-mode byte carries a clock-select bit for each drive (0 for the slower reference, 1 for the faster one), so the same count gives a different time in nanoseconds. The block latches that bit at cycle start and drives it out to the clock source for the whole cycle. It also drives out the two ultra-DMA enable bits. The ultra-DMA timing bytes are stored and read back for the burst logic, which is not part of this block.

Top module: `ata_strobe_timer`

## Requirements
- R1: After reset every timing register reads 0x00, and strobe, busy and cyc_done are low.
- R2: The bank sits at offset 0x10 (PIO), 0x11 (multiword DMA), 0x12 (ultra-DMA drive 0), 0x13 (ultra-DMA drive 1) and 0x14 (clock mode). A read returns the last value written. Other offsets read 0x00, and writes to them change nothing.
- R3: With cyc_mode=0 (PIO), strobe goes high in the clock after the edge that accepts the request. It stays high for max(A,1)*2 clocks, where A is bits 7:4 of the PIO byte.
- R4: After the active phase, strobe stays low for max(R,1)*2 clocks before completion, where R is bits 3:0 of the selected timing byte.
- R5: With cyc_mode=1 (multiword DMA), the counts come from the byte at 0x11 for either drive. Changing that byte changes cycles to drive 0 and to drive 1 alike.
- R6: A count of 0 gives a phase of one unit (2 clocks).
- R7: cyc_done is high for exactly one clock, directly after the last recovery clock. busy is high from the first strobe clock through the cyc_done clock.
- R8: While busy, the block ignores the request input, including a drop and a re-raise.
- R9: The counts are sampled when a cycle starts. A write during a cycle takes effect only from the next cycle.
- R10: dev_fast holds clock-mode bit 0 for drive 0 and bit 1 for drive 1, latched at cycle start. udma_en[1:0] follows clock-mode bits 5:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (reference clock) |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| cyc_req | input | 1 | Cycle request, held until cyc_done |
| cyc_mode | input | 1 | 0 = PIO, 1 = multiword DMA |
| cyc_dev | input | 1 | Target drive |
| strobe | output | 1 | Data strobe, active high |
| busy | output | 1 | Cycle in progress |
| cyc_done | output | 1 | One-clock completion pulse |
| dev_fast | output | 1 | Latched clock select of the target drive |
| udma_en | output | 2 | Ultra-DMA enable per drive |

## Verification
The bench builds the block with its default parameters: two clocks per timing unit and an 8-bit offset. With these values each phase length is an even number of clocks from 2 to 30, so the bench can check the full count range from 0 to 15 in both phases. Both drives and both transfer types are exercised against the clock-select bits. The bench also makes writes and request glitches in the middle of a cycle to test sampling at cycle start and the busy lockout.

// File: rtl/ast_pkg.sv
package ast_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACT  = 2'd1,
        ST_REC  = 2'd2,
        ST_DONE = 2'd3
    } ast_state_e;

    typedef struct packed {
        logic [3:0] act;
        logic [3:0] rec;
    } ast_timing_t;

    typedef struct packed {
        logic [7:0]      pio;
        logic [7:0]      mwdma;
        logic [1:0][7:0] udma;
        logic [7:0]      clkmode;
    } ast_bank_t;

    localparam int NUM_DEV   = 2;
    localparam int OFS_PIO   = 'h10;
    localparam int OFS_MWDMA = 'h11;
    localparam int OFS_UDMA  = 'h12;
    localparam int OFS_CLK   = 'h14;
    localparam int CM_SEL_LSB = 0;
    localparam int CM_UEN_LSB = 4;

    function automatic ast_timing_t split_timing(input logic [7:0] b);
        return ast_timing_t'(b);
    endfunction

endpackage

// File: rtl/ast_regs.sv
module ast_regs
    import ast_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output ast_bank_t         bank
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bank.pio     <= '0;
            bank.mwdma   <= '0;
            bank.clkmode <= '0;
        end else if (wr) begin
            if (addr == ADDR_W'(OFS_PIO))   bank.pio     <= wdata;
            if (addr == ADDR_W'(OFS_MWDMA)) bank.mwdma   <= wdata;
            if (addr == ADDR_W'(OFS_CLK))   bank.clkmode <= wdata;
        end
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_udma
        always_ff @(posedge clk) begin
            if (rst)
                bank.udma[d] <= '0;
            else if (wr && addr == ADDR_W'(OFS_UDMA + d))
                bank.udma[d] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_PIO))   rdata = bank.pio;
        if (addr == ADDR_W'(OFS_MWDMA)) rdata = bank.mwdma;
        if (addr == ADDR_W'(OFS_CLK))   rdata = bank.clkmode;
        for (int d = 0; d < NUM_DEV; d++)
            if (addr == ADDR_W'(OFS_UDMA + d)) rdata = bank.udma[d];
    end

endmodule

// File: rtl/ast_select.sv
module ast_select
    import ast_pkg::*;
(
    input  ast_bank_t   bank,
    input  logic        mode,
    input  logic        dev,
    output ast_timing_t tim,
    output logic        fast
);

    always_comb begin
        tim  = split_timing(mode ? bank.mwdma : bank.pio);
        fast = bank.clkmode[CM_SEL_LSB + int'(dev)];
    end

endmodule

// File: rtl/ast_seq.sv
module ast_seq
    import ast_pkg::*;
#(
    parameter int UNIT_CLKS = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  ast_timing_t tim,
    input  logic        fast,
    output logic        strobe,
    output logic        busy,
    output logic        done,
    output logic        fast_q
);

    localparam int MAX_LEN = 15 * UNIT_CLKS;
    localparam int CW      = $clog2(MAX_LEN + 1);

    ast_state_e    state;
    logic [CW-1:0] cnt;
    logic [3:0]    rec_q;

    function automatic logic [CW-1:0] last_tick(input logic [3:0] n);
        int units;
        units = (n == 4'd0) ? 1 : int'(n);
        return CW'(units * UNIT_CLKS - 1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            rec_q  <= '0;
            fast_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req) begin
                    state  <= ST_ACT;
                    cnt    <= last_tick(tim.act);
                    rec_q  <= tim.rec;
                    fast_q <= fast;
                end
                ST_ACT: begin
                    if (cnt == '0) begin
                        state <= ST_REC;
                        cnt   <= last_tick(rec_q);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_REC: begin
                    if (cnt == '0) state <= ST_DONE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign strobe = (state == ST_ACT);
    assign done   = (state == ST_DONE);
    assign busy   = (state != ST_IDLE);

endmodule

// File: rtl/ata_strobe_timer.sv
module ata_strobe_timer
    import ast_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int UNIT_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              cyc_req,
    input  logic              cyc_mode,
    input  logic              cyc_dev,
    output logic              strobe,
    output logic              busy,
    output logic              cyc_done,
    output logic              dev_fast,
    output logic [1:0]        udma_en
);

    ast_bank_t   bank;
    ast_timing_t tim;
    logic        fast;

    ast_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .bank  (bank)
    );

    ast_select u_sel (
        .bank (bank),
        .mode (cyc_mode),
        .dev  (cyc_dev),
        .tim  (tim),
        .fast (fast)
    );

    ast_seq #(.UNIT_CLKS(UNIT_CLKS)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .req    (cyc_req),
        .tim    (tim),
        .fast   (fast),
        .strobe (strobe),
        .busy   (busy),
        .done   (cyc_done),
        .fast_q (dev_fast)
    );

    assign udma_en = bank.clkmode[CM_UEN_LSB +: 2];

endmodule

// File: rtl/ast_checker.sv
module ast_checker (
    input logic clk,
    input logic rst,
    input logic strobe,
    input logic busy,
    input logic cyc_done,
    input logic dev_fast
);

    assert_idle_after_reset_R1: assert property (@(posedge clk)
        rst |=> (!busy && !strobe && !cyc_done));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        cyc_done |=> !cyc_done);

    assert_done_not_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        !(cyc_done && strobe));

    assert_done_then_idle_R7: assert property (@(posedge clk) disable iff (rst)
        cyc_done |=> !busy);

    assert_start_from_idle_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe) |-> !$past(busy));

    assert_clksel_held_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(dev_fast));

endmodule

bind ata_strobe_timer ast_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .busy     (busy),
    .cyc_done (cyc_done),
    .dev_fast (dev_fast)
);

// File: tb/sim_ata_strobe_timer.sv
module sim_ata_strobe_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       cyc_req = 1'b0;
    logic       cyc_mode = 1'b0;
    logic       cyc_dev = 1'b0;
    logic       strobe, busy, cyc_done, dev_fast;
    logic [1:0] udma_en;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ata_strobe_timer u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_req(cyc_req),
        .cyc_mode(cyc_mode), .cyc_dev(cyc_dev), .strobe(strobe), .busy(busy),
        .cyc_done(cyc_done), .dev_fast(dev_fast), .udma_en(udma_en)
    );

    typedef struct packed {
        logic       mode;
        logic       dev;
        logic [7:0] pio;
        logic [7:0] mw;
        logic [7:0] cm;
        logic [7:0] e_act;
        logic [7:0] e_rec;
        logic       e_fast;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 8'h31, 8'h00, 8'h00, 8'd6,  8'd2,  1'b0},
        '{1'b0, 1'b1, 8'hA3, 8'h00, 8'h02, 8'd20, 8'd6,  1'b1},
        '{1'b1, 1'b0, 8'h00, 8'h62, 8'h01, 8'd12, 8'd4,  1'b1},
        '{1'b1, 1'b1, 8'h00, 8'h62, 8'h01, 8'd12, 8'd4,  1'b0},
        '{1'b1, 1'b1, 8'h00, 8'h81, 8'h03, 8'd16, 8'd2,  1'b1},
        '{1'b0, 1'b0, 8'h00, 8'h55, 8'h00, 8'd2,  8'd2,  1'b0},
        '{1'b0, 1'b1, 8'hFF, 8'h00, 8'h00, 8'd30, 8'd30, 1'b0},
        '{1'b1, 1'b0, 8'h11, 8'h0F, 8'h00, 8'd2,  8'd30, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic run_cyc(input logic mode, input logic dev,
                           input bit mid_wr, input logic [7:0] mid_val,
                           input bit glitch,
                           output int a, output int r, output int f);
        @(negedge clk);
        cyc_mode = mode; cyc_dev = dev; cyc_req = 1'b1;
        a = 0; r = 0;
        @(negedge clk);
        f = int'(dev_fast);
        while (strobe && a < 100) begin
            a++;
            if (mid_wr && a == 1) begin
                reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = mid_val;
            end else begin
                reg_wr = 1'b0;
            end
            @(negedge clk);
        end
        reg_wr = 1'b0;
        while (!cyc_done && r < 100) begin
            r++;
            if (glitch) cyc_req = (r != 2);
            @(negedge clk);
        end
        cyc_req = 1'b0;
        @(negedge clk);
        check("R7 done width", int'(cyc_done), 0);
        check("R7 busy after done", int'(busy), 0);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int a, r, f;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int k = 'h10; k <= 'h14; k++) begin
            rd_reg(8'(k), d);
            check("R1 reg reset", int'(d), 0);
        end
        check("R1 strobe", int'(strobe), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(cyc_done), 0);

        // R3 R4 R5 R6 R10: vector table
        for (int i = 0; i < NV; i++) begin
            wr_reg(8'h10, VECS[i].pio);
            wr_reg(8'h11, VECS[i].mw);
            wr_reg(8'h14, VECS[i].cm);
            run_cyc(VECS[i].mode, VECS[i].dev, 1'b0, 8'h00, 1'b0, a, r, f);
            check("R3 R5 R6 active width", a, int'(VECS[i].e_act));
            check("R4 R6 recovery width", r, int'(VECS[i].e_rec));
            check("R10 dev_fast", f, int'(VECS[i].e_fast));
        end

        // R2: ultra-DMA bytes and unmapped offsets
        wr_reg(8'h12, 8'h85);
        wr_reg(8'h13, 8'h07);
        wr_reg(8'h15, 8'hFF);
        wr_reg(8'h0F, 8'hFF);
        rd_reg(8'h12, d); check("R2 udma dev0", int'(d), 'h85);
        rd_reg(8'h13, d); check("R2 udma dev1", int'(d), 'h07);
        rd_reg(8'h15, d); check("R2 unmapped 0x15", int'(d), 0);
        rd_reg(8'h0F, d); check("R2 unmapped 0x0F", int'(d), 0);
        rd_reg(8'h10, d); check("R2 pio intact", int'(d), 'h11);
        rd_reg(8'h14, d); check("R2 clkmode intact", int'(d), 0);

        // R10: ultra-DMA enables follow bits 5:4
        wr_reg(8'h14, 8'h10);
        check("R10 udma_en dev0", int'(udma_en), 1);
        wr_reg(8'h14, 8'h22);
        check("R10 udma_en dev1", int'(udma_en), 2);

        // R9: write during a cycle applies to the next one
        wr_reg(8'h10, 8'h21);
        run_cyc(1'b0, 1'b0, 1'b1, 8'h55, 1'b0, a, r, f);
        check("R9 current active", a, 4);
        check("R9 current recovery", r, 2);
        run_cyc(1'b0, 1'b1, 1'b0, 8'h00, 1'b0, a, r, f);
        check("R9 next active", a, 10);
        check("R9 next recovery", r, 10);
        check("R10 dev1 fast", f, 1);

        // R8: request glitch during recovery is ignored
        wr_reg(8'h10, 8'h24);
        run_cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, a, r, f);
        check("R8 active", a, 4);
        check("R8 recovery", r, 8);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule